// File: doc/BRIEF.md
# Internal Oscillator Rate Selector

This block produces the system clock enable for a chip whose on-die oscillator block can run at several rates. It receives a fast reference tick (the 8 MHz reference, one pulse per reference period) and a separate low-power slow tick. A free-running postscaler counter divides the reference by powers of two. A 3-bit rate field then picks either the undivided reference or one of the divided rates. At the lowest setting, a source bit decides between the reference divided by 256 and the slow oscillator. All outputs are single-cycle enables in the system clock domain. No clock is gated or switched.

The block also drives the tick for the watchdog and fail-safe monitor, which always comes from the slow oscillator. It reports which clock source is running through three status flags. At most one flag is set at a time, and all clear means the slow oscillator is driving or the internal block has not settled yet. A settle counter keeps the internal block marked unstable for a fixed number of reference ticks after reset or after it is enabled. While it is unstable, the output falls back to the slow tick.

Top module: `iosc_rate_sel`

## Requirements
- R1: After reset the rate field holds 100 and the source bit holds 0, so once settled the output gives one enable per 8 reference ticks. While reset is held, `clk_en`, `wdt_tick` and all status flags are 0.
- R2: With the block settled, rate values 111, 110, 101, 100, 011, 010 and 001 give one `clk_en` pulse per 1, 2, 4, 8, 16, 32 and 64 reference ticks (8 MHz down to 125 kHz).
- R3: With rate value 000, source bit 1 gives one pulse per 256 reference ticks (31.25 kHz). Source bit 0 passes the slow tick to `clk_en`.
- R4: For every divided rate (rate value other than 111), each `clk_en` pulse lasts exactly one system cycle. No two consecutive cycles carry a pulse.
- R5: A write (`cfg_we` high) loads the rate field and the source bit on that clock edge. The new rate drives `clk_en` from the next cycle on, with no deferred update.
- R6: `wdt_tick` repeats `slow_tick` one cycle later, whatever the rate field, source bit or clock mode hold.
- R7: The three status flags `stat_pri`, `stat_int` and `stat_sec` are never set more than one at a time.
- R8: One cycle after its inputs, `stat_pri` is set exactly when `clk_mode` is 00 (primary) and `pri_timer_done` is high. `stat_sec` is set exactly when `clk_mode` is 01 (secondary). `stat_int` is set exactly when `clk_mode` is 10 or 11 (internal), the block is settled, and the slow path is not selected.
- R9: The internal block counts as settled only after `SETTLE_TICKS` (default 16) reference ticks with `int_en` high following reset. It becomes unsettled on the cycle after `int_en` goes low, and it restarts the count when `int_en` returns high. While unsettled, `stat_int` is 0 and `clk_en` repeats `slow_tick` one cycle later.
- R10: In internal mode with rate value 000 and source bit 0, all three status flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle pulse per reference (8 MHz) period |
| slow_tick | input | 1 | One-cycle pulse per slow-oscillator period |
| int_en | input | 1 | Internal oscillator block enabled |
| cfg_we | input | 1 | Load rate field and source bit |
| cfg_rate | input | 3 | Rate field value to load |
| cfg_src | input | 1 | Source bit for rate 000 (1 = reference/256, 0 = slow) |
| clk_mode | input | 2 | Running source: 00 primary, 01 secondary, 1x internal |
| pri_timer_done | input | 1 | Primary start-up timer has expired |
| clk_en | output | 1 | Selected-rate clock enable |
| wdt_tick | output | 1 | Watchdog / fail-safe monitor tick |
| stat_pri | output | 1 | Primary oscillator running |
| stat_int | output | 1 | Internal block settled and driving |
| stat_sec | output | 1 | Secondary oscillator driving |

## Verification
Every cycle, the assertions check that the status flags stay one-hot or clear, that the primary and secondary flags follow their inputs, and that each postscaler tap pulses for a single cycle. They also check that the watchdog tick and the unsettled fallback repeat the slow tick, and that a write lands in the rate field on the next edge. Only the bench's scenarios can show the actual division ratios. The bench counts enables over fixed windows for each rate value, both source-bit settings and two reference patterns. The scenarios also cover the reset default rate, the all-clear flags on the slow path, and the settle time after reset and after re-enable.

// File: rtl/iosc_pkg.sv
package iosc_pkg;

    localparam int RATE_W = 3;

    typedef enum logic [1:0] {
        MODE_PRI     = 2'b00,
        MODE_SEC     = 2'b01,
        MODE_INT     = 2'b10,
        MODE_INT_ALT = 2'b11
    } clk_mode_e;

    typedef enum logic [RATE_W-1:0] {
        RATE_LOW  = 3'b000,
        RATE_125K = 3'b001,
        RATE_250K = 3'b010,
        RATE_500K = 3'b011,
        RATE_1M   = 3'b100,
        RATE_2M   = 3'b101,
        RATE_4M   = 3'b110,
        RATE_8M   = 3'b111
    } rate_sel_e;

    localparam rate_sel_e RATE_RESET = RATE_1M;

    typedef struct packed {
        logic pri_run;
        logic int_run;
        logic sec_run;
    } clk_status_t;

    // Number of postscaler halvings for a rate code; the lowest code uses low_shift.
    function automatic int unsigned rate_shift(input rate_sel_e sel, input int unsigned low_shift);
        if (sel == RATE_LOW) begin
            return low_shift;
        end
        return 32'd7 - 32'(sel);
    endfunction

    function automatic logic mode_is_internal(input clk_mode_e m);
        return m[1];
    endfunction

endpackage

// File: rtl/iosc_postscaler.sv
module iosc_postscaler #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_tick,
    output logic [CNT_W:0]   taps
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (ref_tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign taps[0] = ref_tick;

    for (genvar k = 1; k <= CNT_W; k++) begin : g_tap
        // Tap k fires on the reference tick that rolls the low k counter bits over.
        assign taps[k] = ref_tick & (&cnt_q[k-1:0]);

        AST_TAP_SINGLE: assert property (@(posedge clk) disable iff (rst)
            taps[k] |=> !taps[k]) else $error("divided tap held two cycles"); // R4
    end

endmodule

// File: rtl/iosc_settle.sv
module iosc_settle #(
    parameter int SETTLE_TICKS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_tick,
    input  logic int_en,
    output logic stable
);
    localparam int SC_W = $clog2(SETTLE_TICKS + 1);
    localparam logic [SC_W-1:0] LAST_CNT = SC_W'(SETTLE_TICKS - 1);

    logic [SC_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !int_en) begin
            cnt_q  <= '0;
            stable <= 1'b0;
        end else if (ref_tick && !stable) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST_CNT) begin
                stable <= 1'b1;
            end
        end
    end

    AST_SETTLE_DROP: assert property (@(posedge clk) disable iff (rst)
        !int_en |=> !stable) else $error("stable held while disabled"); // R9

    AST_SETTLE_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(stable) |-> ($past(ref_tick) && $past(int_en))) else $error("stable rose without a tick"); // R9

endmodule

// File: rtl/iosc_status.sv
module iosc_status
    import iosc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  clk_mode_e   mode,
    input  logic        pri_timer_done,
    input  logic        int_drive,
    output clk_status_t status
);
    logic [2:0] flat;

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
        end else begin
            status.pri_run <= (mode == MODE_PRI) && pri_timer_done;
            status.sec_run <= (mode == MODE_SEC);
            status.int_run <= mode_is_internal(mode) && int_drive;
        end
    end

    assign flat = status;

    AST_FLAGS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(flat)) else $error("more than one status flag"); // R7

    AST_PRI_DONE: assert property (@(posedge clk) disable iff (rst)
        status.pri_run |-> ($past(pri_timer_done) && $past(mode) == MODE_PRI)) else $error("primary flag without timer"); // R8

    AST_SEC_MODE: assert property (@(posedge clk) disable iff (rst)
        status.sec_run |-> ($past(mode) == MODE_SEC)) else $error("secondary flag in wrong mode"); // R8

endmodule

// File: rtl/iosc_rate_sel.sv
module iosc_rate_sel
    import iosc_pkg::*;
#(
    parameter int CNT_W        = 8,
    parameter int SETTLE_TICKS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ref_tick,
    input  logic       slow_tick,
    input  logic       int_en,
    input  logic       cfg_we,
    input  logic [2:0] cfg_rate,
    input  logic       cfg_src,
    input  logic [1:0] clk_mode,
    input  logic       pri_timer_done,
    output logic       clk_en,
    output logic       wdt_tick,
    output logic       stat_pri,
    output logic       stat_int,
    output logic       stat_sec
);
    localparam int unsigned LOW_SHIFT = CNT_W;

    rate_sel_e      rate_q;
    logic           src_q;
    logic [CNT_W:0] taps;
    logic           stable;
    logic           slow_sel;
    logic           use_slow;
    logic           tap_pick;
    int unsigned    shift;
    clk_status_t    status;

    always_ff @(posedge clk) begin
        if (rst) begin
            rate_q <= RATE_RESET;
            src_q  <= 1'b0;
        end else if (cfg_we) begin
            rate_q <= rate_sel_e'(cfg_rate);
            src_q  <= cfg_src;
        end
    end

    iosc_postscaler #(.CNT_W(CNT_W)) u_post (
        .clk      (clk),
        .rst      (rst),
        .ref_tick (ref_tick),
        .taps     (taps)
    );

    iosc_settle #(.SETTLE_TICKS(SETTLE_TICKS)) u_settle (
        .clk      (clk),
        .rst      (rst),
        .ref_tick (ref_tick),
        .int_en   (int_en),
        .stable   (stable)
    );

    always_comb begin
        slow_sel = (rate_q == RATE_LOW) && !src_q;
        use_slow = !stable || slow_sel;
        shift    = rate_shift(rate_q, LOW_SHIFT);
        tap_pick = (shift <= LOW_SHIFT) ? taps[shift] : 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_en   <= 1'b0;
            wdt_tick <= 1'b0;
        end else begin
            clk_en   <= use_slow ? slow_tick : tap_pick;
            wdt_tick <= slow_tick;
        end
    end

    iosc_status u_status (
        .clk            (clk),
        .rst            (rst),
        .mode           (clk_mode_e'(clk_mode)),
        .pri_timer_done (pri_timer_done),
        .int_drive      (stable && !slow_sel),
        .status         (status)
    );

    assign stat_pri = status.pri_run;
    assign stat_int = status.int_run;
    assign stat_sec = status.sec_run;

    AST_CFG_LOAD: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (rate_q == $past(cfg_rate) && src_q == $past(cfg_src))) else $error("write not loaded"); // R5

    AST_WDT_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (wdt_tick == $past(slow_tick))) else $error("watchdog tick not from slow source"); // R6

    AST_UNSTABLE_SLOW: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(stable)) |-> (clk_en == $past(slow_tick) && !stat_int)) else $error("unsettled output not slow"); // R9

endmodule

// File: tb/iosc_rate_sel_bench.sv
module iosc_rate_sel_bench;
    localparam int W       = 2048;
    localparam int SLOW_P  = 512;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_tick = 1'b0;
    logic       slow_tick = 1'b0;
    logic       int_en = 1'b1;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_rate = 3'b000;
    logic       cfg_src = 1'b0;
    logic [1:0] clk_mode = 2'b10;
    logic       pri_timer_done = 1'b0;
    logic       clk_en, wdt_tick, stat_pri, stat_int, stat_sec;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int ref_per = 1;
    int en_cnt, wd_cnt, pair_cnt;

    always #10 clk = ~clk;

    iosc_rate_sel u_iosc_rate_sel (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .slow_tick(slow_tick),
        .int_en(int_en), .cfg_we(cfg_we), .cfg_rate(cfg_rate), .cfg_src(cfg_src),
        .clk_mode(clk_mode), .pri_timer_done(pri_timer_done),
        .clk_en(clk_en), .wdt_tick(wdt_tick),
        .stat_pri(stat_pri), .stat_int(stat_int), .stat_sec(stat_sec)
    );

    always @(negedge clk) begin
        cyc++;
        ref_tick  = (ref_per == 1) ? 1'b1 : ((cyc % ref_per) == 0);
        slow_tick = ((cyc % SLOW_P) == 7);
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] rate, input logic src);
        @(negedge clk);
        cfg_we = 1'b1; cfg_rate = rate; cfg_src = src;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic count_window();
        logic prev;
        en_cnt = 0; wd_cnt = 0; pair_cnt = 0; prev = 1'b0;
        repeat (W) begin
            @(negedge clk);
            if (clk_en) en_cnt++;
            if (wdt_tick) wd_cnt++;
            if (clk_en && prev) pair_cnt++;
            prev = clk_en;
        end
    endtask

    function automatic int flags();
        return {29'd0, stat_pri, stat_int, stat_sec};
    endfunction

    task automatic settle_wait(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: run did not complete actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        settle_wait(4);
        check("R1 clk_en in reset", int'(clk_en), 0);
        check("R1 wdt_tick in reset", int'(wdt_tick), 0);
        check("R1 flags in reset", flags(), 0);
        @(negedge clk); rst = 1'b0;
        settle_wait(3);
        check("R9 stat_int before settle", int'(stat_int), 0);
        settle_wait(30);
        check("R9 stat_int after settle", int'(stat_int), 1);
        count_window();
        check("R1 default rate count", en_cnt, W >> 3);

        // R2 R3 R4 R5 R6: sweep of every rate code and both reference patterns
        for (int p = 1; p <= 2; p++) begin
            ref_per = p;
            for (int s = 7; s >= 1; s--) begin
                wr(3'(s), 1'b0);
                count_window();
                check($sformatf("R2 R5 rate %0d refper %0d", s, p), en_cnt, (W / p) >> (7 - s));
                check("R6 wdt count", wd_cnt, W / SLOW_P);
                if (s != 7) check("R4 no back-to-back pulses", pair_cnt, 0);
            end
            wr(3'b000, 1'b1);
            count_window();
            check($sformatf("R3 ref/256 refper %0d", p), en_cnt, (W / p) >> 8);
            check("R4 no back-to-back at /256", pair_cnt, 0);
            check("R8 int flag at ref/256", flags(), 3'b010);
            wr(3'b000, 1'b0);
            count_window();
            check($sformatf("R3 slow source refper %0d", p), en_cnt, W / SLOW_P);
            check("R6 wdt on slow path", wd_cnt, W / SLOW_P);
            check("R10 flags clear on slow path", flags(), 0);
        end
        ref_per = 1;

        // R9 fallback while disabled
        wr(3'b111, 1'b0);
        @(negedge clk); int_en = 1'b0;
        settle_wait(3);
        check("R9 stat_int cleared by disable", int'(stat_int), 0);
        count_window();
        check("R9 fallback to slow tick", en_cnt, W / SLOW_P);
        @(negedge clk); int_en = 1'b1;
        settle_wait(8);
        check("R9 still settling after re-enable", int'(stat_int), 0);
        settle_wait(20);
        check("R9 settled after re-enable", int'(stat_int), 1);

        // R7 R8 status flag combinations
        clk_mode = 2'b00; pri_timer_done = 1'b0; settle_wait(2);
        check("R8 primary, timer pending", flags(), 3'b000);
        pri_timer_done = 1'b1; settle_wait(2);
        check("R7 R8 primary running", flags(), 3'b100);
        clk_mode = 2'b01; settle_wait(2);
        check("R7 R8 secondary running", flags(), 3'b001);
        clk_mode = 2'b11; settle_wait(2);
        check("R7 R8 internal alt code", flags(), 3'b010);
        clk_mode = 2'b10; settle_wait(2);
        check("R8 internal mode", flags(), 3'b010);
        wr(3'b000, 1'b0); settle_wait(2);
        check("R10 internal on slow oscillator", flags(), 3'b000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule